// File: doc/BRIEF.md
# Load-Reserved Reservation Tracker

This block keeps the single reservation of one hart for a load-reserved / store-conditional pair. It sits beside the hart's private cache. A load-reserved op records the cache line it touched. A later store-conditional is granted only if that reservation is still alive and covers the same line. Every store-conditional returns a result code and wipes the reservation, whatever the outcome. The reservation is also lost when an interrupt is taken, when the hart makes an ordinary store to the reserved line, or when another agent's probe or eviction for that line is acknowledged. An acknowledged probe is the way a remote write reaches this hart, so any remote write makes the next store-conditional fail, even if the value written equals the old one.

To guarantee forward progress for short retry loops, the tracker holds back its acknowledgement of a probe or eviction that targets the reserved line while the reservation is young. The reservation is young for a bounded window of `HOLD_CYCLES` clock cycles, 16 by default. Probes to other lines are always acknowledged at once. When the window runs out, a pending probe to the reserved line is acknowledged in that same cycle and the reservation dies.

The control is a three-state machine:
- **IDLE**: no reservation.
- **YOUNG**: reservation held and the hold window is running.
- **OLD**: reservation held and the window has expired.

The transitions are:
- **reserve**: any state goes to YOUNG when a load-reserved op arrives. The window restarts.
- **expire**: YOUNG goes to OLD on the last cycle of the window.
- **kill**: YOUNG or OLD goes to IDLE on any of these events: a store-conditional, an interrupt, a local store to the reserved line, or an acknowledged probe to the reserved line.

A load-reserved op takes precedence over a kill in the same cycle.

Top module: `resv_tracker`

## Requirements
- R1: After reset no reservation is held. A store-conditional then returns code 1 (no reservation) with `sc_wr_en` low, and a probe to any line is acknowledged in the same cycle.
- R2: After a load-reserved op, a store-conditional to any byte of the same line (address bits above `LINE_OFF_W`) returns code 0 with `sc_wr_en` high in the same cycle, provided no kill event came between them.
- R3: Every store-conditional clears the reservation, so a second store-conditional returns code 1.
- R4: A store-conditional to a line other than the reserved one returns code 2 with `sc_wr_en` low. It still clears the reservation.
- R5: A taken interrupt clears the reservation, so a later store-conditional returns code 1. An interrupt in the same cycle as a matching store-conditional makes that store-conditional return code 3 with `sc_wr_en` low.
- R6: An ordinary local store to the reserved line clears the reservation. A local store to another line leaves it intact.
- R7: While in YOUNG, a probe to the reserved line is not acknowledged. A probe held from the cycle after the load-reserved op is refused for exactly `HOLD_CYCLES` cycles and acknowledged in the next cycle.
- R8: A probe to a line other than the reserved one is acknowledged in the same cycle and leaves the reservation intact.
- R9: In OLD, a probe to the reserved line is acknowledged at once and clears the reservation. A matching store-conditional in the same cycle returns code 3.
- R10: A new load-reserved op replaces the existing reservation and restarts the hold window.
- R11: A load-reserved op in the same cycle as a kill event leaves the new reservation in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved op this cycle |
| lr_addr | input | ADDR_W | Load-reserved byte address |
| sc_valid | input | 1 | Store-conditional op this cycle |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_wr_en | output | 1 | Store-conditional may write (same cycle) |
| sc_code | output | 2 | Result while sc_valid: 0 ok, 1 no reservation, 2 other line, 3 lost this cycle |
| st_valid | input | 1 | Ordinary local store this cycle |
| st_addr | input | ADDR_W | Local store byte address |
| irq_taken | input | 1 | Interrupt taken this cycle |
| snp_req | input | 1 | Probe or eviction request from another agent |
| snp_addr | input | ADDR_W | Probe byte address |
| snp_ack | output | 1 | Probe acknowledged this cycle |

## Verification
The bound checker checks these rules on every cycle:
- probes to other lines, or probes while IDLE, are acknowledged at once;
- no probe is refused once `HOLD_CYCLES` cycles have passed since the last load-reserved op;
- every store-conditional, interrupt, matching local store and acknowledged matching probe leads to IDLE;
- a write grant never happens without a matching live reservation.

Only the bench's scenarios can show the other properties. These are: the exact length of the stall, the code-3 cases where a loss and a store-conditional meet in one cycle, the precedence of a load-reserved op over a kill, and the window restarting on a replacement. The bench covers them with directed sequences and with a long constrained-random run checked against a cycle model.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_YOUNG = 2'd1,
        RS_OLD   = 2'd2
    } resv_state_t;

    typedef enum logic [1:0] {
        SC_OK       = 2'd0,
        SC_NO_RESV  = 2'd1,
        SC_MISMATCH = 2'd2,
        SC_LOST     = 2'd3
    } sc_code_t;
endpackage

// File: rtl/resv_line_match.sv
module resv_line_match #(
    parameter int TAG_W = 26
) (
    input  logic             en,
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             hit
);
    always_comb hit = en && (tag_a == tag_b);
endmodule

// File: rtl/resv_hold_timer.sv
module resv_hold_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expiring
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST  = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= LIMIT;
        else if (restart)
            count_q <= '0;
        else if (count_q < LIMIT)
            count_q <= count_q + 1'b1;
    end

    always_comb expiring = (count_q == LAST) && !restart;
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
    parameter int ADDR_W      = 32,
    parameter int LINE_OFF_W  = 6,
    parameter int HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_valid,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    output logic              sc_wr_en,
    output logic [1:0]        sc_code,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              irq_taken,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ack
);
    import resv_pkg::*;

    localparam int TAG_W = ADDR_W - LINE_OFF_W;

    resv_state_t      state_q, state_d;
    logic [TAG_W-1:0] resv_tag_q;
    logic             held;
    logic             sc_hit, st_hit, snp_hit;
    logic             tmr_expiring;
    logic             stall, snp_take, kill;
    sc_code_t         code;

    always_comb held = (state_q != RS_IDLE);

    resv_line_match #(.TAG_W(TAG_W)) i_sc_match (
        .en(held), .tag_a(sc_addr[ADDR_W-1:LINE_OFF_W]), .tag_b(resv_tag_q), .hit(sc_hit));
    resv_line_match #(.TAG_W(TAG_W)) i_st_match (
        .en(held), .tag_a(st_addr[ADDR_W-1:LINE_OFF_W]), .tag_b(resv_tag_q), .hit(st_hit));
    resv_line_match #(.TAG_W(TAG_W)) i_snp_match (
        .en(held), .tag_a(snp_addr[ADDR_W-1:LINE_OFF_W]), .tag_b(resv_tag_q), .hit(snp_hit));

    resv_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .restart(lr_valid), .expiring(tmr_expiring));

    // Probe handling and kill conditions
    always_comb begin
        stall    = snp_req && snp_hit && (state_q == RS_YOUNG);
        snp_take = snp_req && !stall && snp_hit;
        kill     = sc_valid || irq_taken || (st_valid && st_hit) || snp_take;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  state_d = RS_IDLE;
            RS_YOUNG: begin
                if (kill)              state_d = RS_IDLE;   // kill
                else if (tmr_expiring) state_d = RS_OLD;    // expire
            end
            RS_OLD:   if (kill) state_d = RS_IDLE;          // kill
            default:  state_d = RS_IDLE;
        endcase
        if (lr_valid) state_d = RS_YOUNG;                   // reserve
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            resv_tag_q <= '0;
        end else begin
            state_q <= state_d;
            if (lr_valid) resv_tag_q <= lr_addr[ADDR_W-1:LINE_OFF_W];
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RS_IDLE: code = SC_NO_RESV;
            RS_YOUNG, RS_OLD: begin
                if (!sc_hit)                    code = SC_MISMATCH;
                else if (irq_taken || snp_take) code = SC_LOST;
                else                            code = SC_OK;
            end
            default: code = SC_NO_RESV;
        endcase
        sc_code  = code;
        sc_wr_en = sc_valid && (code == SC_OK);
        snp_ack  = snp_req && !stall;
    end
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk
    import resv_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_OFF_W  = 6,
    parameter int HOLD_CYCLES = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         lr_valid,
    input logic [ADDR_W-1:0]            lr_addr,
    input logic                         sc_valid,
    input logic [ADDR_W-1:0]            sc_addr,
    input logic                         sc_wr_en,
    input logic [1:0]                   sc_code,
    input logic                         st_valid,
    input logic [ADDR_W-1:0]            st_addr,
    input logic                         irq_taken,
    input logic                         snp_req,
    input logic [ADDR_W-1:0]            snp_addr,
    input logic                         snp_ack,
    input resv_state_t                  state_q,
    input logic [ADDR_W-LINE_OFF_W-1:0] resv_tag_q
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= LIMIT;
        else if (lr_valid)       age <= '0;
        else if (age < LIMIT)    age <= age + 1'b1;
    end

    logic sc_same, st_same, snp_same, held;
    always_comb begin
        held     = (state_q != RS_IDLE);
        sc_same  = sc_addr[ADDR_W-1:LINE_OFF_W]  == resv_tag_q;
        st_same  = st_addr[ADDR_W-1:LINE_OFF_W]  == resv_tag_q;
        snp_same = snp_addr[ADDR_W-1:LINE_OFF_W] == resv_tag_q;
    end

    AST_IDLE_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !held |-> sc_code == 2'd1 && !sc_wr_en); // R1
    AST_WR_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr_en |-> held && sc_same && !irq_taken); // R2
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !lr_valid |=> state_q == RS_IDLE); // R3
    AST_MISMATCH_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && held && !sc_same |-> !sc_wr_en && sc_code == 2'd2); // R4
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken && !lr_valid |=> state_q == RS_IDLE); // R5
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && held && st_same && !lr_valid |=> state_q == RS_IDLE); // R6
    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req && !snp_ack |-> held && snp_same && age < LIMIT); // R7
    AST_FOREIGN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req && (!held || !snp_same) |-> snp_ack); // R8
    AST_OLD_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack && held && snp_same && !lr_valid |=> state_q == RS_IDLE); // R9
    AST_LR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lr_valid |=> state_q == RS_YOUNG
                     && resv_tag_q == $past(lr_addr[ADDR_W-1:LINE_OFF_W])); // R10
endmodule

bind resv_tracker resv_tracker_chk #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .HOLD_CYCLES(HOLD_CYCLES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_wr_en(sc_wr_en), .sc_code(sc_code),
    .st_valid(st_valid), .st_addr(st_addr), .irq_taken(irq_taken),
    .snp_req(snp_req), .snp_addr(snp_addr), .snp_ack(snp_ack),
    .state_q(state_q), .resv_tag_q(resv_tag_q)
);

// File: tb/test_resv_tracker.sv
module test_resv_tracker;
    localparam int AW   = 32;
    localparam int OFF  = 6;
    localparam int HOLD = 16;
    localparam logic [AW-1:0] LA = 32'h0000_1000;
    localparam logic [AW-1:0] LB = 32'h0000_2040;
    localparam logic [AW-1:0] Z  = '0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lr_valid = 0, sc_valid = 0, st_valid = 0, irq_taken = 0, snp_req = 0;
    logic [AW-1:0] lr_addr = '0, sc_addr = '0, st_addr = '0, snp_addr = '0;
    logic sc_wr_en, snp_ack;
    logic [1:0] sc_code;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_valid = 0;
    logic [AW-OFF-1:0] m_tag = '0;
    int m_age = 0;
    bit last_ack;
    int last_code;

    always #4 clk = ~clk;

    resv_tracker #(.ADDR_W(AW), .LINE_OFF_W(OFF), .HOLD_CYCLES(HOLD)) i_resv_tracker (
        .clk(clk), .rst_n(rst_n), .lr_valid(lr_valid), .lr_addr(lr_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_wr_en(sc_wr_en), .sc_code(sc_code),
        .st_valid(st_valid), .st_addr(st_addr), .irq_taken(irq_taken),
        .snp_req(snp_req), .snp_addr(snp_addr), .snp_ack(snp_ack));

    function automatic logic [AW-OFF-1:0] line_of(input logic [AW-1:0] a);
        return a[AW-1:OFF];
    endfunction

    function automatic bit exp_ack(input bit snp, input logic [AW-1:0] a);
        bit young = m_valid && (m_age < HOLD);
        return snp && !(young && m_valid && line_of(a) == m_tag);
    endfunction

    function automatic int exp_code(input logic [AW-1:0] a, input bit irq, input bit take);
        if (!m_valid)              return 1;
        if (line_of(a) != m_tag)   return 2;
        if (irq || take)           return 3;
        return 0;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare against model, advance model.
    task automatic step(input bit lr, input logic [AW-1:0] la,
                        input bit sc, input logic [AW-1:0] sa,
                        input bit st, input logic [AW-1:0] ta,
                        input bit irq, input bit snp, input logic [AW-1:0] pa,
                        input string tag);
        bit ea, take;
        int ec;
        @(negedge clk);
        lr_valid = lr; lr_addr = la; sc_valid = sc; sc_addr = sa;
        st_valid = st; st_addr = ta; irq_taken = irq; snp_req = snp; snp_addr = pa;
        #1;
        ea   = exp_ack(snp, pa);
        take = ea && m_valid && line_of(pa) == m_tag;
        ec   = exp_code(sa, irq, take);
        check(int'(snp_ack), int'(ea), {tag, " ack"});
        if (sc) begin
            check(int'(sc_code), ec, {tag, " code"});
            check(int'(sc_wr_en), int'(ec == 0), {tag, " wr_en"});
        end
        last_ack = snp_ack; last_code = int'(sc_code);
        if (lr) begin
            m_valid = 1; m_tag = line_of(la); m_age = 0;
        end else if (sc || irq || (st && m_valid && line_of(ta) == m_tag) || take) begin
            m_valid = 0;
        end else if (m_age < HOLD) begin
            m_age++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, Z, 0, Z, 0, Z, 0, 0, Z, "idle");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int stalls;
        void'($urandom(32'd20210629));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        step(0, Z, 1, LA, 0, Z, 0, 1, LA, "R1");
        check(last_code, 1, "R1 literal code");
        check(int'(last_ack), 1, "R1 literal ack");

        // R2 success on another byte of same line, R3 second sc fails
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R2 lr");
        idle(3);
        step(0, Z, 1, LA + 32'h3c, 0, Z, 0, 0, Z, "R2");
        check(last_code, 0, "R2 literal");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R3");
        check(last_code, 1, "R3 literal");

        // R4 mismatch, then cleared
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R4 lr");
        step(0, Z, 1, LB, 0, Z, 0, 0, Z, "R4");
        check(last_code, 2, "R4 literal");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R4 cleared");
        check(last_code, 1, "R4 cleared literal");

        // R5 interrupt
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R5 lr");
        step(0, Z, 0, Z, 0, Z, 1, 0, Z, "R5 irq");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R5");
        check(last_code, 1, "R5 literal");
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R5 lr");
        step(0, Z, 1, LA, 0, Z, 1, 0, Z, "R5 same cycle");
        check(last_code, 3, "R5 same-cycle literal");

        // R6 local stores
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R6 lr");
        step(0, Z, 0, Z, 1, LB, 0, 0, Z, "R6 other");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R6 kept");
        check(last_code, 0, "R6 kept literal");
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R6 lr");
        step(0, Z, 0, Z, 1, LA + 32'h8, 0, 0, Z, "R6 same");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R6 killed");
        check(last_code, 1, "R6 killed literal");

        // R7 stall length, R9 cleared by the late ack
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R7 lr");
        stalls = 0;
        for (int i = 0; i < HOLD + 4; i++) begin
            step(0, Z, 0, Z, 0, Z, 0, 1, LA, "R7");
            if (last_ack) break;
            stalls++;
        end
        check(stalls, HOLD, "R7 stall cycles");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R9 after ack");
        check(last_code, 1, "R9 literal");

        // R8 foreign probe during window
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R8 lr");
        step(0, Z, 0, Z, 0, Z, 0, 1, LB, "R8");
        check(int'(last_ack), 1, "R8 literal ack");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R8 kept");
        check(last_code, 0, "R8 kept literal");

        // R9 old reservation: immediate ack with same-cycle sc
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R9 lr");
        idle(HOLD + 4);
        step(0, Z, 1, LA, 0, Z, 0, 1, LA, "R9");
        check(int'(last_ack), 1, "R9 ack literal");
        check(last_code, 3, "R9 code literal");

        // R10 replacement restarts window
        step(1, LA, 0, Z, 0, Z, 0, 0, Z, "R10 lr A");
        idle(10);
        step(1, LB, 0, Z, 0, Z, 0, 0, Z, "R10 lr B");
        stalls = 0;
        for (int i = 0; i < HOLD + 4; i++) begin
            step(0, Z, 0, Z, 0, Z, 0, 1, LB, "R10");
            if (last_ack) break;
            stalls++;
        end
        check(stalls, HOLD, "R10 restarted window");

        // R11 lr wins over same-cycle kill
        step(1, LA, 1, LB, 0, Z, 1, 0, Z, "R11 lr+kill");
        step(0, Z, 1, LA, 0, Z, 0, 0, Z, "R11");
        check(last_code, 0, "R11 literal");

        // constrained random against the model
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a [4];
            for (int k = 0; k < 4; k++)
                a[k] = {24'h0, 2'($urandom_range(0, 2)), OFF'($urandom)};
            step($urandom_range(0, 99) < 10, a[0],
                 $urandom_range(0, 99) < 10, a[1],
                 $urandom_range(0, 99) < 8,  a[2],
                 $urandom_range(0, 99) < 3,
                 $urandom_range(0, 99) < 35, a[3], "R7/R8/R9 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule